// File: doc/BRIEF.md
# Keyed Independent Watchdog

This block is a watchdog timer that sits on a simple 32-bit register bus and produces a one-cycle reset request when software stops servicing it. Every control action goes through 16-bit magic values written to a key register. One value arms the watchdog. Another value restarts the countdown. A third value opens the two configuration registers for writing. Any other value closes them again. A free-running tick input is divided by a selectable power-of-two prescaler. Each prescaled tick decrements a 12-bit down-counter.

The prescaler and reload values that software writes are not used straight away. Each one waits a fixed number of tick cycles before the counting logic takes it over. While a value is waiting, a status flag is set so that software can poll until the new setting is in force. Once armed, the watchdog keeps running until the block itself is reset. Each expiry raises the reset request, then the counter reloads and counts down again.

Top module: `kwd_top`

## Requirements
- R1: Registers are selected by address bits 3:2. Key is 0x0 and reads as zero. Prescaler code is 0x4, bits 2:0. Reload value is 0x8, bits 11:0. Status is 0xC. Read data is combinational, and unused bits read as zero.
- R2: After reset the watchdog is stopped and locked, the prescaler code is 0, the reload value is 0xFFF, status is 0 and reset_req is low.
- R3: Writing 0x5555 to the key (write data bits 15:0) unlocks the prescaler and reload registers. Writing any other key value locks them. Writes to either register while locked leave its content unchanged.
- R4: Writing 0xCCCC to the key arms the watchdog. Once armed, no bus write stops it. reset_req never rises before the watchdog is armed.
- R5: Writing 0xAAAA to the key, or 0xCCCC, loads the counter from the reload value in force and restarts the prescaler division. A refresh in the same cycle as an expiry cancels that expiry.
- R6: Prescaler code k divides the tick by 4·2^k for k from 0 to 6. Code 7 also divides by 256. Only cycles with tick high advance the prescaler.
- R7: With a reload value in force of N-1, reset_req is high for exactly the one cycle after the clock edge that carries the N-th prescaled tick since the last load. The counter then reloads and counts again.
- R8: Status bit 0 flags a pending prescaler update and bit 1 flags a pending reload update. An accepted write sets its flag. The flag clears 3 tick cycles later, at which point the new value takes effect. A new write while the flag is set restarts the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Free-running timebase enable, one cycle per tick |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| reset_req | output | 1 | One-cycle reset request on expiry |

## Verification
Almost all internal state of this block is hidden: the counter, the prescaler count and the lock show at the ports only through the timing of reset_req and through the effect of later writes. A counter that is off by one shows as a pulse one prescaled tick early or late, which means 4 to 256 cycles away from the expected one. A lock left open shows the next time a write that should be ignored changes the readback. A delay counter that is wrong shows on the status read within three tick cycles. It also shows later as a shifted timeout, because the reload value took effect at the wrong time. For these reasons the bench compares both outputs against a reference model on every clock, so that each of these faults shows as an exact cycle of divergence.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam logic [15:0] KEY_OPEN  = 16'h5555;
  localparam logic [15:0] KEY_ARM   = 16'hCCCC;
  localparam logic [15:0] KEY_KICK  = 16'hAAAA;

  typedef enum logic [1:0] {
    SEL_KEY = 2'd0,
    SEL_PSC = 2'd1,
    SEL_RLD = 2'd2,
    SEL_STS = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    KEY_OTHER,
    KEY_IS_OPEN,
    KEY_IS_ARM,
    KEY_IS_KICK
  } key_kind_e;

  function automatic key_kind_e classify_key(input logic [15:0] v);
    if (v == KEY_OPEN) return KEY_IS_OPEN;
    if (v == KEY_ARM)  return KEY_IS_ARM;
    if (v == KEY_KICK) return KEY_IS_KICK;
    return KEY_OTHER;
  endfunction

  // division ratio for a prescaler code: 4 shifted by the code, saturated
  function automatic int unsigned div_for_code(input int unsigned code,
                                               input int unsigned max_shift);
    int unsigned s;
    s = (code > max_shift) ? max_shift : code;
    return 32'd4 << s;
  endfunction

endpackage

// File: rtl/kwd_shadow.sv
// Holds one configuration value plus its delayed copy used by the counting logic.
module kwd_shadow #(
  parameter int unsigned W         = 12,
  parameter logic [W-1:0] RST_VAL  = '1,
  parameter int unsigned UPD_TICKS = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cfg_o,
  output logic [W-1:0] act_o,
  output logic         pend_o
);
  localparam int unsigned DLY_W = $clog2(UPD_TICKS + 1);

  logic [W-1:0]     cfg_q, act_q;
  logic [DLY_W-1:0] dly_q;
  logic             due;

  assign due    = tick_i && (dly_q == DLY_W'(1)) && !wr_i;
  assign pend_o = (dly_q != '0);
  assign cfg_o  = cfg_q;
  assign act_o  = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= RST_VAL;
      act_q <= RST_VAL;
      dly_q <= '0;
    end else begin
      if (wr_i) begin
        cfg_q <= wdata_i;
        dly_q <= DLY_W'(UPD_TICKS);
      end else if (tick_i && dly_q != '0) begin
        dly_q <= dly_q - DLY_W'(1);
      end
      if (due) act_q <= cfg_q;
    end
  end

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> pend_o);
  // R8
  pend_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o) |-> (act_o == cfg_o));
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned UPD_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_we_i,
  input  logic [3:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              run_o,
  output logic              load_o,
  output logic [CODE_W-1:0] act_code_o,
  output logic [CNT_W-1:0]  act_reload_o
);
  reg_sel_e          sel;
  key_kind_e         kind;
  logic              key_wr, psc_wr_ok, rld_wr_ok;
  logic              unlocked_q, running_q;
  logic [CODE_W-1:0] cfg_code;
  logic [CNT_W-1:0]  cfg_reload;
  logic              pend_code, pend_reload;
  logic              unused_bus;

  assign sel        = reg_sel_e'(bus_addr_i[3:2]);
  assign kind       = classify_key(bus_wdata_i[15:0]);
  assign key_wr     = bus_we_i && (sel == SEL_KEY);
  assign psc_wr_ok  = bus_we_i && (sel == SEL_PSC) && unlocked_q;
  assign rld_wr_ok  = bus_we_i && (sel == SEL_RLD) && unlocked_q;
  assign load_o     = key_wr && ((kind == KEY_IS_KICK) || (kind == KEY_IS_ARM));
  assign run_o      = running_q;
  assign unused_bus = ^{bus_wdata_i[31:16], bus_addr_i[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      running_q  <= 1'b0;
    end else begin
      if (key_wr) unlocked_q <= (kind == KEY_IS_OPEN);
      if (key_wr && kind == KEY_IS_ARM) running_q <= 1'b1;
    end
  end

  kwd_shadow #(.W(CODE_W), .RST_VAL('0), .UPD_TICKS(UPD_TICKS)) u_code (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(psc_wr_ok),
    .wdata_i(bus_wdata_i[CODE_W-1:0]), .cfg_o(cfg_code), .act_o(act_code_o),
    .pend_o(pend_code));

  kwd_shadow #(.W(CNT_W), .RST_VAL('1), .UPD_TICKS(UPD_TICKS)) u_reload (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(rld_wr_ok),
    .wdata_i(bus_wdata_i[CNT_W-1:0]), .cfg_o(cfg_reload), .act_o(act_reload_o),
    .pend_o(pend_reload));

  always_comb begin
    bus_rdata_o = '0;
    case (sel)
      SEL_PSC: bus_rdata_o = 32'(cfg_code);
      SEL_RLD: bus_rdata_o = 32'(cfg_reload);
      SEL_STS: bus_rdata_o = {30'b0, pend_reload, pend_code};
      default: bus_rdata_o = '0;
    endcase
  end

  // R3
  locked_psc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_i && sel == SEL_PSC && !unlocked_q) |=> $stable(cfg_code));
  // R3
  locked_rld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_i && sel == SEL_RLD && !unlocked_q) |=> $stable(cfg_reload));
  // R4
  never_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(running_q));
endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler
  import kwd_pkg::*;
#(
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned MAX_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              event_o
);
  localparam int unsigned PCNT_W = MAX_SHIFT + 2;

  logic [PCNT_W-1:0] pc_q, term;

  assign term    = PCNT_W'(div_for_code(32'(code_i), MAX_SHIFT) - 32'd1);
  assign event_o = run_i && tick_i && (pc_q >= term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pc_q <= '0;
    else if (clear_i)          pc_q <= '0;
    else if (event_o)          pc_q <= '0;
    else if (run_i && tick_i)  pc_q <= pc_q + PCNT_W'(1);
  end

  // R5
  clear_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !event_o);
  // R6
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clear_i) |=> $stable(pc_q));
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             load_i,
  input  logic             event_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  assign expire_o  = event_i && (cnt_q == '0) && !load_i;
  assign rst_req_o = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      req_q <= 1'b0;
    end else begin
      req_q <= expire_o;
      if (load_i)       cnt_q <= reload_i;
      else if (event_i) cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - CNT_W'(1);
    end
  end

  // R7
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  // R4
  armed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> run_i);
  // R7
  reload_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> (cnt_q == $past(reload_i)));
endmodule

// File: rtl/kwd_top.sv
module kwd_top #(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned MAX_SHIFT = 6,
  parameter int unsigned UPD_TICKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        reset_req
);
  logic              running, load, presc_event, expire;
  logic [CODE_W-1:0] act_code;
  logic [CNT_W-1:0]  act_reload;

  kwd_regs #(.CNT_W(CNT_W), .CODE_W(CODE_W), .UPD_TICKS(UPD_TICKS)) u_regs (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .run_o(running), .load_o(load), .act_code_o(act_code),
    .act_reload_o(act_reload));

  kwd_prescaler #(.CODE_W(CODE_W), .MAX_SHIFT(MAX_SHIFT)) u_presc (
    .clk(clk), .rst_n(rst_n), .run_i(running), .tick_i(tick),
    .clear_i(load), .code_i(act_code), .event_o(presc_event));

  kwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(running), .load_i(load),
    .event_i(presc_event), .reload_i(act_reload), .expire_o(expire),
    .rst_req_o(reset_req));

  // R5
  kick_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !reset_req);
  // R7
  expire_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> reset_req);
endmodule

// File: tb/kwd_top_tb.sv
module kwd_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        reset_req;

  int checks = 0, fails = 0, cyc = 0, tick_every = 1;
  bit done = 0;

  kwd_top u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .reset_req(reset_req));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) tick = (tick_every <= 1) ? 1'b1 : ((cyc % tick_every) == 0);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- reference model ----------------
  int m_run, m_unl, m_cps, m_crl, m_aps, m_arl, m_pps, m_prl, m_pc, m_cnt;
  bit m_req;

  function automatic int mdiv(input int c);
    return (c >= 6) ? 256 : 4 * (1 << c);
  endfunction

  function automatic logic [31:0] mread(input logic [3:0] a);
    case (a[3:2])
      2'd1:    return 32'(m_cps);
      2'd2:    return 32'(m_crl);
      2'd3:    return {30'b0, m_prl > 0, m_pps > 0};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit kw, kick, ev;
    int k, was_unl;
    if (!rst_n) begin
      m_run = 0; m_unl = 0; m_cps = 0; m_aps = 0; m_crl = 4095; m_arl = 4095;
      m_pps = 0; m_prl = 0; m_pc = 0; m_cnt = 4095; m_req = 0;
    end else begin
      kw   = bus_we && bus_addr[3:2] == 2'd0;
      k    = int'(bus_wdata[15:0]);
      kick = kw && (k == 'hAAAA || k == 'hCCCC);
      ev   = m_run != 0 && tick && m_pc >= mdiv(m_aps) - 1;
      m_req = ev && m_cnt == 0 && !kick;
      if (kick) begin m_cnt = m_arl; m_pc = 0; end
      else if (ev) begin m_cnt = (m_cnt == 0) ? m_arl : m_cnt - 1; m_pc = 0; end
      else if (m_run != 0 && tick) m_pc++;
      was_unl = m_unl;
      if (kw && k == 'hCCCC) m_run = 1;
      if (kw) m_unl = (k == 'h5555);
      if (bus_we && bus_addr[3:2] == 2'd1 && was_unl != 0) begin
        m_cps = int'(bus_wdata[2:0]); m_pps = 3;
      end else if (tick && m_pps > 0) begin
        m_pps--; if (m_pps == 0) m_aps = m_cps;
      end
      if (bus_we && bus_addr[3:2] == 2'd2 && was_unl != 0) begin
        m_crl = int'(bus_wdata[11:0]); m_prl = 3;
      end else if (tick && m_prl > 0) begin
        m_prl--; if (m_prl == 0) m_arl = m_crl;
      end
    end
  end

  // per-cycle comparison, sampled after the edge has settled
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(reset_req === m_req, "R7 reset_req vs model", reset_req, m_req);
      chk(bus_rdata === mread(bus_addr),
          (bus_addr[3:2] == 2'd3) ? "R8 status vs model" : "R1 readback vs model",
          bus_rdata, mread(bus_addr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; #1;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic wait_req(output int n);
    n = 1;
    while (!reset_req && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(1);
  endtask

  task automatic run_tests();
    int n;
    do_reset();
    // R2: reset state
    rd_chk(4'h4, 32'h0,   "R2 prescaler after reset");
    rd_chk(4'h8, 32'hFFF, "R2 reload after reset");
    rd_chk(4'hC, 32'h0,   "R2 status after reset");
    rd_chk(4'h0, 32'h0,   "R1 key reads zero");
    chk(reset_req == 1'b0, "R2 reset_req after reset", reset_req, 0);
    // R4: no request while not armed
    idle(300);
    chk(reset_req == 1'b0, "R4 idle before arm", reset_req, 0);
    // R3: locked writes ignored
    bus_wr(4'h4, 32'h5); bus_wr(4'h8, 32'h123);
    rd_chk(4'h4, 32'h0,   "R3 locked prescaler write");
    rd_chk(4'h8, 32'hFFF, "R3 locked reload write");
    // R3/R8: unlocked write, pending flag life
    bus_wr(4'h0, 32'h5555);
    bus_wr(4'h8, 32'hFFFF_0009);
    rd_chk(4'h8, 32'h9, "R3 unlocked reload write");
    rd_chk(4'hC, 32'h2, "R8 reload pending set");
    idle(2);
    rd_chk(4'hC, 32'h2, "R8 reload still pending");
    idle(1);
    rd_chk(4'hC, 32'h0, "R8 reload pending cleared");
    // R3: other key relocks
    bus_wr(4'h0, 32'h1234);
    bus_wr(4'h8, 32'h3);
    rd_chk(4'h8, 32'h9, "R3 relocked by other key");
    // R7: arm and time the first two expiries (N=10, div 4)
    bus_wr(4'h0, 32'hCCCC);
    wait_req(n);
    chk(n == 41, "R7 first timeout cycles", n, 41);
    @(negedge clk);
    chk(reset_req == 1'b0, "R7 pulse one cycle", reset_req, 0);
    wait_req(n);
    chk(n == 40, "R7 periodic timeout cycles", n, 40);
    // R5: regular refresh keeps it quiet
    idle(2);
    for (int i = 0; i < 10; i++) begin
      bus_wr(4'h0, 32'hAAAA);
      idle(30);
      chk(reset_req == 1'b0, "R5 refresh prevents expiry", reset_req, 0);
    end
    // R5: refresh on the expiry edge wins
    bus_wr(4'h0, 32'hAAAA);
    idle(38);
    bus_wr(4'h0, 32'hAAAA);
    chk(reset_req == 1'b0, "R5 refresh on expiry edge", reset_req, 0);
    // R4: attempts to stop do nothing
    bus_wr(4'h0, 32'h0); bus_wr(4'h0, 32'h5555); bus_wr(4'h4, 32'h0);
    wait_req(n);
    chk(reset_req == 1'b1, "R4 still running after stop attempts", reset_req, 1);
    // R6: code 7 behaves as 256
    bus_wr(4'h0, 32'h5555); bus_wr(4'h4, 32'h7);
    idle(4);
    rd_chk(4'hC, 32'h0, "R8 prescaler pending cleared");
    bus_wr(4'h0, 32'hAAAA);
    wait_req(n);
    chk(n == 2561, "R6 code 7 divides by 256", n, 2561);
    // R6: code 1 with a sparse tick (model compares every cycle)
    bus_wr(4'h0, 32'h5555); bus_wr(4'h4, 32'h1); bus_wr(4'h8, 32'h4);
    tick_every = 3;
    idle(12);
    bus_wr(4'h0, 32'hAAAA);
    bus_addr = 4'hC;
    wait_req(n);
    chk(reset_req == 1'b1, "R6 sparse tick expiry seen", reset_req, 1);
    bus_wr(4'h0, 32'h5555); bus_wr(4'h8, 32'h7); bus_wr(4'h8, 32'h2);
    bus_addr = 4'hC;
    idle(200);
    tick_every = 1;
    // R2/R7: default reload after a fresh reset, div 4, N=4096
    do_reset();
    bus_wr(4'h0, 32'hCCCC);
    wait_req(n);
    chk(n == 16385, "R7 default timeout cycles", n, 16385);
  endtask

  initial begin
    fork
      begin run_tests(); end
      begin
        wait (cyc >= 100000);
        chk(1'b0, "watchdog expired", cyc, 100000);
      end
    join_any
    disable fork;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule